// File: doc/BRIEF.md
# Display Memory Row Scan Controller

This block keeps the picture for one column-driver slice of a dot-matrix panel in a local row memory, so that the host only sends new data when the image changes. A scan-start pulse returns the row pointer to the top row. Each pulse on the latch line moves the pointer down one row, so the frame height is simply the number of latch pulses between two scan starts. No register sets it. Frames of 64 to 200 rows are supported.

On the rising edge of a latch pulse, the addressed row is read into a holding register. In transfer mode, the same edge also stores the write-register contents into that row. The read happens first, so a row that is rewritten still shows its previous contents until the next frame. On the falling edge, the held row moves to the visible display latch and the pointer advances. The pointer stops at the last row if extra pulses arrive.

Every column gets a 2-bit level select, built from its pixel and the AC-drive phase. A separate code means blank. While the blank input is low, all columns show the blank code, but the memory and the display latch keep their contents.

All latch and scan inputs are synchronous levels sampled on `clk`. Edges are found by comparing each sample with the previous one.

Top module: `rowScanDriver`

## Requirements
- R1: After reset, `dispLatch` is all zeros and the row pointer is at row 0.
- R2: On a latch rising edge with `xferMode` high, `wrData` is stored into the row the pointer addresses.
- R3: On a latch rising edge, the addressed row is read before any write to it. A row rewritten on that pulse therefore shows its old contents.
- R4: `dispLatch` changes only one clock after the latch line is first sampled low following a high, which is the falling edge. A rising edge alone leaves it unchanged.
- R5: Each latch falling edge advances the pointer by one. The n-th pulse after a scan start displays row n-1.
- R6: A high `scanStart` sample sets the pointer to row 0 on the next clock. This takes priority over an advance in the same clock.
- R7: The pointer saturates at row ROWS-1 (199). Pulses beyond the 200th read and write row 199.
- R8: While `blankN` is low, every 2-bit field of `segSel` is 00. The memory and `dispLatch` are left unchanged.
- R9: While `blankN` is high, field i of `segSel` (bits 2i+1:2i) equals {1, dispLatch[i] XOR acFlag}. The code 11 selects the on level and 10 selects the off level.
- R10: A latch pulse with `xferMode` low writes nothing into the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchPulse | input | 1 | Row latch line, sampled level |
| scanStart | input | 1 | Frame start, resets row pointer |
| acFlag | input | 1 | AC-drive phase |
| blankN | input | 1 | Active-low forced blank |
| xferMode | input | 1 | Data-transfer mode enable |
| wrData | input | 80 | Write-register contents |
| dispLatch | output | 80 | Displayed row bits |
| segSel | output | 160 | Per-column 2-bit level select |

## Verification
A 64-row frame is tried in four passes that alternate transfer mode, data seed and AC phase. A first write pass is followed by a rewrite pass that must still show the first seed, which separates read-before-write from write-first ordering. A pass with transfer mode off must leave the second seed in place, which catches stray writes. A 205-pulse frame with distinct data on every pulse shows whether the pointer saturates or wraps. A lone rising edge separates an update on the falling edge from one on the rising edge. A blank interval followed by a read pass shows that blanking acts only on the outputs.

// File: rtl/rowScanPkg.sv
package rowScanPkg;
  typedef struct packed {
    logic readRow;
    logic writeRow;
    logic showRow;
  } scanStrobe_t;

  localparam logic [1:0] SEL_BLANK = 2'b00;
  localparam logic [1:0] SEL_OFF   = 2'b10;
  localparam logic [1:0] SEL_ON    = 2'b11;
endpackage

// File: rtl/rowScanCtrl.sv
module rowScanCtrl
  import rowScanPkg::*;
#(
  parameter int ROWS = 200,
  localparam int AW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          latchPulse,
  input  logic          scanStart,
  input  logic          xferMode,
  output scanStrobe_t   strobes,
  output logic [AW-1:0] rowAddr
);
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  logic latchPrev;
  logic latchRise;
  logic latchFall;

  always_ff @(posedge clk) begin
    if (!rstN) latchPrev <= 1'b0;
    else       latchPrev <= latchPulse;
  end

  assign latchRise = latchPulse & ~latchPrev;
  assign latchFall = ~latchPulse & latchPrev;

  always_comb begin
    strobes.readRow  = latchRise;
    strobes.writeRow = latchRise & xferMode;
    strobes.showRow  = latchFall;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              rowAddr <= '0;
    else if (scanStart)                     rowAddr <= '0;
    else if (latchFall && rowAddr != LAST_ROW) rowAddr <= rowAddr + 1'b1;
  end
endmodule

// File: rtl/rowScanData.sv
module rowScanData
  import rowScanPkg::*;
#(
  parameter int ROWS = 200,
  parameter int COLS = 80,
  localparam int AW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobes,
  input  logic [AW-1:0]     rowAddr,
  input  logic [COLS-1:0]   wrData,
  input  logic              acFlag,
  input  logic              blankN,
  output logic [COLS-1:0]   dispLatch,
  output logic [2*COLS-1:0] segSel
);
  logic [COLS-1:0] rowMem [ROWS];
  logic [COLS-1:0] holdRow;

  // Memory write; the read below samples the pre-write contents.
  always_ff @(posedge clk) begin
    if (strobes.writeRow) rowMem[rowAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdRow   <= '0;
      dispLatch <= '0;
    end else begin
      if (strobes.readRow) holdRow   <= rowMem[rowAddr];
      if (strobes.showRow) dispLatch <= holdRow;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_comb begin
      if (!blankN)                     segSel[2*c+1:2*c] = SEL_BLANK;
      else if (dispLatch[c] ^ acFlag)  segSel[2*c+1:2*c] = SEL_ON;
      else                             segSel[2*c+1:2*c] = SEL_OFF;
    end
  end
endmodule

// File: rtl/rowScanDriver.sv
module rowScanDriver
  import rowScanPkg::*;
#(
  parameter int ROWS = 200,
  parameter int COLS = 80,
  localparam int AW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchPulse,
  input  logic              scanStart,
  input  logic              acFlag,
  input  logic              blankN,
  input  logic              xferMode,
  input  logic [COLS-1:0]   wrData,
  output logic [COLS-1:0]   dispLatch,
  output logic [2*COLS-1:0] segSel
);
  scanStrobe_t   strobes;
  logic [AW-1:0] rowAddr;

  rowScanCtrl #(.ROWS(ROWS)) ctrl (
    .clk(clk), .rstN(rstN), .latchPulse(latchPulse), .scanStart(scanStart),
    .xferMode(xferMode), .strobes(strobes), .rowAddr(rowAddr)
  );

  rowScanData #(.ROWS(ROWS), .COLS(COLS)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rowAddr(rowAddr),
    .wrData(wrData), .acFlag(acFlag), .blankN(blankN),
    .dispLatch(dispLatch), .segSel(segSel)
  );
endmodule

// File: rtl/rowScanDriver_chk.sv
module rowScanDriver_chk
  import rowScanPkg::*;
#(
  parameter int ROWS = 200,
  parameter int COLS = 80,
  localparam int AW = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              scanStart,
  input logic              blankN,
  input logic [COLS-1:0]   dispLatch,
  input logic [2*COLS-1:0] segSel,
  input logic [AW-1:0]     rowAddr,
  input scanStrobe_t       strobes
);
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  logic allOddSet;
  always_comb begin
    allOddSet = 1'b1;
    for (int c = 0; c < COLS; c++) allOddSet &= segSel[2*c+1];
  end

  assert_scan_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |=> rowAddr == '0);

  assert_row_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    rowAddr <= LAST_ROW);

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.showRow && !scanStart && rowAddr != LAST_ROW) |=> rowAddr == $past(rowAddr) + 1'b1);

  assert_hold_display_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.showRow |=> $stable(dispLatch));

  assert_blank_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !blankN |-> segSel == '0);

  assert_drive_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    blankN |-> allOddSet);
endmodule

bind rowScanDriver rowScanDriver_chk #(.ROWS(ROWS), .COLS(COLS)) chk (
  .clk(clk), .rstN(rstN), .scanStart(scanStart), .blankN(blankN),
  .dispLatch(dispLatch), .segSel(segSel), .rowAddr(rowAddr), .strobes(strobes)
);

// File: tb/rowScanDriver_test.sv
module rowScanDriver_test;
  localparam int ROWS = 200;
  localparam int COLS = 80;
  localparam int FRAME = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchPulse = 1'b0;
  logic scanStart = 1'b0;
  logic acFlag = 1'b0;
  logic blankN = 1'b1;
  logic xferMode = 1'b0;
  logic [COLS-1:0] wrData = '0;
  logic [COLS-1:0] dispLatch;
  logic [2*COLS-1:0] segSel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rowScanDriver #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rstN(rstN), .latchPulse(latchPulse), .scanStart(scanStart),
    .acFlag(acFlag), .blankN(blankN), .xferMode(xferMode), .wrData(wrData),
    .dispLatch(dispLatch), .segSel(segSel)
  );

  // Pass table: {check, xfer, ac, writeSeed[7:0], expectSeed[7:0]}
  localparam int NPASS = 4;
  localparam logic [18:0] PASSES [NPASS] = '{
    {1'b0, 1'b1, 1'b0, 8'hA5, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h3C, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'hF0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h0F, 8'h3C}
  };

  function automatic logic [COLS-1:0] pat(input logic [7:0] seed, input int row);
    logic [7:0] r8;
    r8 = 8'(row);
    return {5{seed, r8}};
  endfunction

  function automatic logic [2*COLS-1:0] expSel(input logic [COLS-1:0] d,
                                               input logic ac, input logic bn);
    logic [2*COLS-1:0] s;
    for (int c = 0; c < COLS; c++)
      s[2*c+1 -: 2] = bn ? {1'b1, d[c] ^ ac} : 2'b00;
    return s;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [2*COLS-1:0] act, input logic [2*COLS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startScan();
    scanStart = 1'b1;
    @(negedge clk);
    scanStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [COLS-1:0] d);
    wrData = d;
    latchPulse = 1'b1;
    @(negedge clk);
    latchPulse = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [COLS-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dispLatch == '0, "R1 reset latch", 160'(dispLatch), 160'(0));

    // Table walk: R2, R3, R5, R9, R10
    for (int p = 0; p < NPASS; p++) begin
      xferMode = PASSES[p][17];
      acFlag   = PASSES[p][16];
      startScan();
      for (int r = 0; r < FRAME; r++) begin
        pulse(pat(PASSES[p][15:8], r));
        if (PASSES[p][18]) begin
          check(dispLatch == pat(PASSES[p][7:0], r), "R2/R3/R5/R10 row data",
                160'(dispLatch), 160'(pat(PASSES[p][7:0], r)));
          if (r % 16 == 0)
            check(segSel == expSel(dispLatch, acFlag, 1'b1), "R9 drive code",
                  segSel, expSel(dispLatch, acFlag, 1'b1));
        end
      end
    end
    xferMode = 1'b0;

    // R6: scan start mid-frame returns to row 0
    startScan();
    repeat (5) pulse('0);
    startScan();
    pulse('0);
    check(dispLatch == pat(8'h3C, 0), "R6 scan restart", 160'(dispLatch), 160'(pat(8'h3C, 0)));

    // R4: rising edge alone does not update display
    held = dispLatch;
    latchPulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dispLatch == held, "R4 no update on rise", 160'(dispLatch), 160'(held));
    latchPulse = 1'b0;
    @(negedge clk);
    check(dispLatch == pat(8'h3C, 1), "R4 update on fall", 160'(dispLatch), 160'(pat(8'h3C, 1)));

    // R8: blanking
    held = dispLatch;
    blankN = 1'b0;
    @(negedge clk);
    check(segSel == '0, "R8 blank codes", segSel, '0);
    pulse('0);
    check(segSel == '0, "R8 blank during pulse", segSel, '0);
    blankN = 1'b1;
    @(negedge clk);
    check(segSel == expSel(dispLatch, acFlag, 1'b1), "R8/R9 unblank", segSel,
          expSel(dispLatch, acFlag, 1'b1));
    startScan();
    for (int r = 0; r < 3; r++) begin
      pulse('0);
      check(dispLatch == pat(8'h3C, r), "R8 memory kept", 160'(dispLatch), 160'(pat(8'h3C, r)));
    end

    // R7: saturation at last row
    xferMode = 1'b1;
    startScan();
    for (int r = 0; r < ROWS + 5; r++) pulse(pat(8'hE0, r));
    xferMode = 1'b0;
    startScan();
    for (int r = 0; r < ROWS + 2; r++) begin
      pulse('0);
      if (r == 0 || r == ROWS - 2)
        check(dispLatch == pat(8'hE0, r), "R7 lower rows", 160'(dispLatch), 160'(pat(8'hE0, r)));
      if (r >= ROWS - 1)
        check(dispLatch == pat(8'hE0, ROWS + 4), "R7 saturated row", 160'(dispLatch),
              160'(pat(8'hE0, ROWS + 4)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule